// File: doc/BRIEF.md
# Addressable bit latch with 1-of-N demultiplexer

This block keeps eight single-bit storage cells and writes one data line into the cell chosen by a three-bit address. Two active-low controls select the mode. `le_n` is the write strobe and `clr_n` is the clear. Together they choose one of four modes: addressed write, hold, active-high demultiplexer, and clear. A common use is serial-to-parallel loading, one bit per address. With the data line tied high, the demultiplexer mode also serves as a 3-to-8 decoder.

The storage is a set of synchronous registers on the system clock. The output bus is combinational from those registers and from the current inputs. In write mode the addressed output follows `din` at once, while the other outputs show their stored bits. The stored bit takes the `din` value present at the last rising clock edge before `le_n` goes high. In demultiplexer mode the output shows only the decoded address gated by `din`, and the stored contents are neither shown nor changed. Clear mode forces the outputs low at once and zeroes the storage at the next clock edge. The address should change only in hold mode. A change during write mode is committed at every clock edge.

An asynchronous active-low reset clears the storage. Its release passes through a short synchronizer before it reaches the storage registers.

Top module: `addr_latch8`

## Requirements
- R1: While `rst_n` is low, all stored bits are zero. After reset, in hold mode, `q` reads 0x00.
- R2: In write mode (`le_n`=0, `clr_n`=1), `q[n]` equals `din`, where n is the binary value of `addr` (addr[2] MSB, addr[0] LSB, so 3'b101 selects `q[5]`). Every other bit of `q` shows its stored value.
- R3: In write mode, each rising clock edge stores `din` into bit n and leaves the other stored bits unchanged. After a return to hold, bit n keeps the `din` value of the last edge in write mode.
- R4: In hold mode (`le_n`=1, `clr_n`=1), `q` shows the stored bits, and changes of `din` and `addr` affect neither `q` nor the storage.
- R5: In demultiplexer mode (`le_n`=0, `clr_n`=0), `q[n]` equals `din` and every other bit of `q` is 0.
- R6: In demultiplexer mode with `din`=1, exactly one bit of `q` is high: the bit whose index is the value of `addr`. This is the 3-to-8 decoder function.
- R7: Demultiplexer mode does not alter the storage. On return to hold, `q` shows the contents stored before that mode.
- R8: In clear mode (`le_n`=1, `clr_n`=0), `q` is 0x00 for any `din` and `addr`.
- R9: A rising clock edge in clear mode zeroes all stored bits, so a following hold mode reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; storage updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Data line written to, or routed to, the addressed bit |
| addr | input | 3 | Bit select; the binary value n picks bit n |
| le_n | input | 1 | Active-low write strobe (mode select) |
| clr_n | input | 1 | Active-low clear (mode select) |
| q | output | 8 | Output bus |

## Verification
On every cycle, the assertions check four things. Hold and demultiplexer modes leave the storage untouched. A clear edge zeroes it. A write edge alters no bit other than the addressed one. The output bus matches the mode rule for the write view, the demultiplexer pattern and the clear state. Only the bench scenarios can show what is captured at the last edge before a write ends, and that stored contents come back after a spell in demultiplexer mode. The same holds for the full address-to-bit mapping swept over all eight positions, and for the effect of a reset in the middle of a run.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  // Mode code is {le_n, clr_n}.
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } al_mode_e;

endpackage

// File: rtl/al_rst_sync.sv
module al_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nxt;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/al_mode_dec.sv
module al_mode_dec
  import addr_latch_pkg::*;
(
  input  logic     le_n,
  input  logic     clr_n,
  output al_mode_e mode
);

  always_comb begin
    unique case ({le_n, clr_n})
      2'b00:   mode = MODE_DEMUX;
      2'b01:   mode = MODE_WRITE;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/al_onehot_dec.sv
module al_onehot_dec #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = $clog2(WIDTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WIDTH-1:0]  sel
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/al_store.sv
module al_store
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  al_mode_e         mode,
  input  logic [WIDTH-1:0] sel,
  input  logic             din,
  output logic [WIDTH-1:0] store,
  output logic [WIDTH-1:0] merge
);

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_nxt;
  logic             store_en;

  // Stored bits with the selected position replaced by the data line.
  assign merge = (store_q & ~sel) | (sel & {WIDTH{din}});

  always_comb begin
    store_en  = 1'b0;
    store_nxt = store_q;
    case (mode)
      MODE_WRITE: begin
        store_en  = 1'b1;
        store_nxt = merge;
      end
      MODE_CLEAR: begin
        store_en  = 1'b1;
        store_nxt = '0;
      end
      default: begin
        store_en  = 1'b0;
        store_nxt = store_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (store_en) begin
      store_q <= store_nxt;
    end
  end

  assign store = store_q;

  // R4: hold leaves storage unchanged
  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(store_q));

  // R7: demultiplexer mode leaves storage unchanged
  p_demux_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX) |=> $stable(store_q));

  // R9: clear edge zeroes storage
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> (store_q == '0));

  // R3: a write edge touches only the selected bit
  p_write_only_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> (((store_q ^ $past(store_q)) & ~$past(sel)) == '0));

endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = $clog2(WIDTH),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              le_n,
  input  logic              clr_n,
  output logic [WIDTH-1:0]  q
);

  logic             rst_sync_n;
  al_mode_e         mode;
  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] store;
  logic [WIDTH-1:0] merge;

  al_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  al_mode_dec u_mode_dec (
    .le_n  (le_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  al_onehot_dec #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_addr_dec (
    .addr (addr),
    .sel  (sel)
  );

  al_store #(.WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .mode  (mode),
    .sel   (sel),
    .din   (din),
    .store (store),
    .merge (merge)
  );

  always_comb begin
    case (mode)
      MODE_WRITE: q = merge;
      MODE_DEMUX: q = sel & {WIDTH{din}};
      MODE_CLEAR: q = '0;
      default:    q = store;
    endcase
  end

  // R2: addressed output follows din, others show storage
  p_write_view_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_WRITE) |-> ((((q >> addr) & 1) == WIDTH'(din)) &&
                              ((q & ~sel) == (store & ~sel))));

  // R5: demultiplexer output has at most one high bit, at the address
  p_demux_pattern_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_DEMUX) |-> (($countones(q) == int'(din)) &&
                              (((q >> addr) & 1) == WIDTH'(din))));

  // R8: clear mode drives all outputs low
  p_clear_out_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == MODE_CLEAR) |-> (q == '0));

endmodule

// File: tb/tb_addr_latch8.sv
`timescale 1ns/1ps
module tb_addr_latch8;

  logic       clk;
  logic       rst_n;
  logic       din;
  logic [2:0] addr;
  logic       le_n;
  logic       clr_n;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  addr_latch8 dut (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .addr  (addr),
    .le_n  (le_n),
    .clr_n (clr_n),
    .q     (q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Vector: {le_n, clr_n, din, addr[2:0], expected q[7:0]}
  localparam int NVEC = 20;
  localparam logic [13:0] VEC [NVEC] = '{
    {2'b11, 1'b1, 3'd5, 8'h00},
    {2'b01, 1'b1, 3'd5, 8'h20},
    {2'b01, 1'b1, 3'd0, 8'h21},
    {2'b01, 1'b0, 3'd5, 8'h01},
    {2'b01, 1'b1, 3'd7, 8'h81},
    {2'b01, 1'b1, 3'd2, 8'h85},
    {2'b11, 1'b0, 3'd2, 8'h85},
    {2'b11, 1'b1, 3'd3, 8'h85},
    {2'b00, 1'b1, 3'd3, 8'h08},
    {2'b00, 1'b1, 3'd6, 8'h40},
    {2'b00, 1'b0, 3'd6, 8'h00},
    {2'b11, 1'b0, 3'd0, 8'h85},
    {2'b01, 1'b0, 3'd7, 8'h05},
    {2'b11, 1'b1, 3'd7, 8'h05},
    {2'b10, 1'b1, 3'd4, 8'h00},
    {2'b11, 1'b1, 3'd4, 8'h00},
    {2'b01, 1'b1, 3'd4, 8'h10},
    {2'b00, 1'b1, 3'd1, 8'h02},
    {2'b10, 1'b0, 3'd0, 8'h00},
    {2'b11, 1'b0, 3'd0, 8'h00}
  };

  function automatic string tag_of(logic [1:0] m, int idx);
    if (idx == 0) return "R1";
    case (m)
      2'b01:   return "R2";
      2'b11:   return (idx == 11) ? "R7" : (idx == 13) ? "R3" : (idx == 15) ? "R9" : "R4";
      2'b00:   return (idx == 8 || idx == 9) ? "R6" : "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] exp_q);
    checks++;
    if (q !== exp_q) begin
      errors++;
      $display("FAIL %s: q=%h expected %h at %0t", tag, q, exp_q, $time);
    end
  endtask

  task automatic drive(logic l, logic c, logic d, logic [2:0] a);
    @(negedge clk);
    le_n  = l;
    clr_n = c;
    din   = d;
    addr  = a;
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    le_n  = 1'b1;
    clr_n = 1'b1;
    din   = 1'b0;
    addr  = 3'd0;
    repeat (3) @(posedge clk);
    #1 check("R1", 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:8]);
      check(tag_of(VEC[i][13:12], i), VEC[i][7:0]);
    end

    // R6: decoder sweep over all addresses
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 1'b0, 1'b1, 3'(a));
      check("R6", 8'(1 << a));
    end

    // R3: write alternating pattern into each bit, then hold
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, 1'b1, a[0], 3'(a));
    end
    drive(1'b1, 1'b1, 1'b0, 3'd0);
    check("R3", 8'hAA);

    // R3: only the last edge before le_n rises is kept
    drive(1'b0, 1'b1, 1'b1, 3'd2);
    drive(1'b0, 1'b1, 1'b0, 3'd2);
    drive(1'b1, 1'b1, 1'b1, 3'd2);
    check("R3", 8'hAA);

    // R4: hold ignores data and address swings over several edges
    for (int a = 0; a < 8; a++) begin
      drive(1'b1, 1'b1, ~a[0], 3'(7 - a));
    end
    check("R4", 8'hAA);

    // R7: demux spell keeps storage
    drive(1'b0, 1'b0, 1'b1, 3'd0);
    check("R5", 8'h01);
    drive(1'b0, 1'b0, 1'b0, 3'd0);
    check("R5", 8'h00);
    drive(1'b1, 1'b1, 1'b1, 3'd0);
    check("R7", 8'hAA);

    // R1: reset in the middle of a run clears storage
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1", 8'h00);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1", 8'h00);

    // R8 / R9: clear with data present
    drive(1'b0, 1'b1, 1'b1, 3'd6);
    check("R2", 8'h40);
    drive(1'b1, 1'b0, 1'b1, 3'd6);
    check("R8", 8'h00);
    drive(1'b1, 1'b1, 1'b1, 3'd6);
    check("R9", 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: q=%h expected completion", q);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule